// File: doc/BRIEF.md
# Single-Clock FIFO with Threshold Status Flags

This block is a first-in first-out buffer for one clock domain. Words of a configurable width (18 bits by default) are stored on the rising clock edge while the active-low write strobe is held and the buffer has room. A word is moved into a registered data output while the active-low read strobe is held and the buffer holds data. The depth is a parameter, meant for 256 to 4096 words.

Five active-low status outputs describe the occupancy: empty, full, half-full, and two threshold flags whose limits are supplied at run time by a neighbouring configuration block. The low threshold `ae_lvl` is a word count. The high threshold `af_lvl` is a distance from full. All flags are registered from the occupancy that the current edge produces, so each one is valid in the cycle after the edge that changes it. An active-low output-enable input is passed on as a drive-enable output for the pad logic outside this block. The data output itself always carries the output register.

Top module: `thresh_fifo`

## Requirements
- R1: While `rst_n` is low, the occupancy is zero and both pointers return to the first slot. `full_n`, `afull_n` and `hfull_n` read 1, `empty_n` and `aempty_n` read 0, and `dout` reads all zeros.
- R2: A word on `din` is stored at a rising edge only when `wr_en_n` is 0 and the buffer is not full. A write strobe while full changes neither the contents nor the occupancy.
- R3: At a rising edge with `rd_en_n` at 0 and the buffer not empty, `dout` takes the oldest stored word. In every other cycle `dout` keeps its value.
- R4: Words leave in the order they were stored, across pointer wrap-around.
- R5: A write and a read accepted at the same edge leave the occupancy unchanged.
- R6: `empty_n` is 0 exactly when the occupancy is 0, valid the cycle after the edge that sets that occupancy.
- R7: `full_n` is 0 exactly when the occupancy equals DEPTH. The occupancy never exceeds DEPTH.
- R8: `aempty_n` is 0 when the occupancy is at most `ae_lvl`, and 1 when it is `ae_lvl`+1 or more.
- R9: `afull_n` is 0 when the occupancy plus `af_lvl` is DEPTH or more, and 1 otherwise.
- R10: `hfull_n` is 0 when the occupancy is above DEPTH/2, and 1 when it is DEPTH/2 or less.
- R11: `dout_en` is 1 when `oe_n` is 0 and 0 when `oe_n` is 1. `oe_n` has no effect on `dout` or on the flags.
- R12: A read strobe while the buffer is empty is ignored: `dout` holds and the occupancy stays 0, even if a write is accepted at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by the write and read sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_n | input | 1 | Active-low write strobe |
| din | input | DW (18) | Write data |
| rd_en_n | input | 1 | Active-low read strobe |
| oe_n | input | 1 | Active-low output enable |
| ae_lvl | input | $clog2(DEPTH)+1 | Low threshold, in words |
| af_lvl | input | $clog2(DEPTH)+1 | High threshold, as a distance from full |
| dout | output | DW (18) | Registered read data |
| dout_en | output | 1 | Drive enable for the data output |
| empty_n | output | 1 | Low when empty |
| full_n | output | 1 | Low when full |
| aempty_n | output | 1 | Low at or below the low threshold |
| afull_n | output | 1 | Low within the high threshold of full |
| hfull_n | output | 1 | Low when more than half full |

## Verification
The bench fills the buffer to DEPTH and keeps strobing writes there. A design that lets those through would overwrite the oldest word or wrap the occupancy, and the later drain would return the wrong data. It reads while empty, alone and together with a write, where a wrong design would move stale memory into `dout` or drive the occupancy below zero. It walks every flag one word at a time across its edge, with thresholds of 0 and of small non-zero values, which exposes off-by-one comparisons such as `<` written for `<=`. A reset in the middle of a run with data present must clear the flags and `dout`, and the traffic that follows must start from the first slot.

// File: rtl/tf_pkg.sv
`timescale 1ns/1ps
package tf_pkg;

    // Active-low status flags, one field per output
    typedef struct packed {
        logic empty_n;
        logic full_n;
        logic aempty_n;
        logic afull_n;
        logic hfull_n;
    } tf_flags_t;

    // Flag values while reset is held (occupancy zero)
    localparam tf_flags_t TF_FLAGS_RST = '{
        empty_n:  1'b0,
        full_n:   1'b1,
        aempty_n: 1'b0,
        afull_n:  1'b1,
        hfull_n:  1'b1
    };

endpackage

// File: rtl/tf_ctrl.sv
`timescale 1ns/1ps
module tf_ctrl #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_n,
    input  logic          rd_en_n,
    output logic          wr_go,
    output logic          rd_go,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] cnt_nxt
);

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_C  = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        wr_go = !wr_en_n && (st_q.cnt != DEPTH_C);
        rd_go = !rd_en_n && (st_q.cnt != '0);

        if (wr_go) begin
            st_d.wp = (st_q.wp == LAST_C) ? '0 : st_q.wp + 1'b1;
        end
        if (rd_go) begin
            st_d.rp = (st_q.rp == LAST_C) ? '0 : st_q.rp + 1'b1;
        end

        unique case ({wr_go, rd_go})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ptr  = st_q.wp;
    assign rd_ptr  = st_q.rp;
    assign cnt_nxt = st_d.cnt;

    // R7: occupancy stays within the storage
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= DEPTH_C);

    // R2: a full buffer with no read stays full whatever the write strobe does
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == DEPTH_C && rd_en_n) |=> (st_q.cnt == DEPTH_C));

    // R12: an empty buffer with no write stays empty whatever the read strobe does
    p_no_underflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0 && wr_en_n) |=> (st_q.cnt == '0));

    // R5: accepted write plus accepted read keeps the occupancy
    p_balanced_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && rd_go) |=> $stable(st_q.cnt));

endmodule

// File: rtl/tf_flags.sv
`timescale 1ns/1ps
module tf_flags
    import tf_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_nxt,
    input  logic [CW-1:0] ae_lvl,
    input  logic [CW-1:0] af_lvl,
    output tf_flags_t     flags
);

    localparam int            XW     = CW + 1;
    localparam logic [XW-1:0] DEPTH_X = XW'(DEPTH);
    localparam logic [XW-1:0] HALF_X  = XW'(DEPTH / 2);

    tf_flags_t       flg_d, flg_q;
    logic [XW-1:0]   cnt_x;
    logic [XW-1:0]   room_sum;

    always_comb begin
        cnt_x          = {1'b0, cnt_nxt};
        room_sum       = cnt_x + {1'b0, af_lvl};
        flg_d.empty_n  = (cnt_nxt != '0);
        flg_d.full_n   = (cnt_x != DEPTH_X);
        flg_d.aempty_n = (cnt_nxt > ae_lvl);
        flg_d.afull_n  = (room_sum < DEPTH_X);
        flg_d.hfull_n  = (cnt_x <= HALF_X);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flg_q <= TF_FLAGS_RST;
        end else begin
            flg_q <= flg_d;
        end
    end

    assign flags = flg_q;

    // R6: empty and full never show together
    p_empty_full_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!flg_q.empty_n && !flg_q.full_n));

    // R8: empty implies at or below the low threshold
    p_empty_in_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !flg_q.empty_n |-> !flg_q.aempty_n);

    // R9: full implies within the high threshold
    p_full_in_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !flg_q.full_n |-> !flg_q.afull_n);

    // R10: full implies more than half full
    p_full_over_half_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !flg_q.full_n |-> !flg_q.hfull_n);

endmodule

// File: rtl/tf_store.sv
`timescale 1ns/1ps
module tf_store #(
    parameter int DEPTH = 256,
    parameter int DW    = 18,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_go,
    input  logic [AW-1:0] wr_ptr,
    input  logic [DW-1:0] din,
    input  logic          rd_go,
    input  logic [AW-1:0] rd_ptr,
    output logic [DW-1:0] dout
);

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] dout_d, dout_q;

    always_ff @(posedge clk) begin
        if (wr_go) begin
            mem[wr_ptr] <= din;
        end
    end

    always_comb begin
        dout_d = dout_q;
        if (rd_go) begin
            dout_d = mem[rd_ptr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else begin
            dout_q <= dout_d;
        end
    end

    assign dout = dout_q;

    // R3: without an accepted read the output register holds
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> $stable(dout_q));

endmodule

// File: rtl/thresh_fifo.sv
`timescale 1ns/1ps
module thresh_fifo
    import tf_pkg::*;
#(
    parameter  int DEPTH = 256,
    parameter  int DW    = 18,
    localparam int CW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_n,
    input  logic [DW-1:0] din,
    input  logic          rd_en_n,
    input  logic          oe_n,
    input  logic [CW-1:0] ae_lvl,
    input  logic [CW-1:0] af_lvl,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    output logic          empty_n,
    output logic          full_n,
    output logic          aempty_n,
    output logic          afull_n,
    output logic          hfull_n
);

    localparam int AW = $clog2(DEPTH);

    logic          wr_go, rd_go;
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_nxt;
    tf_flags_t     flags;

    tf_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_n (wr_en_n),
        .rd_en_n (rd_en_n),
        .wr_go   (wr_go),
        .rd_go   (rd_go),
        .wr_ptr  (wr_ptr),
        .rd_ptr  (rd_ptr),
        .cnt_nxt (cnt_nxt)
    );

    tf_flags #(.DEPTH(DEPTH), .CW(CW)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_nxt (cnt_nxt),
        .ae_lvl  (ae_lvl),
        .af_lvl  (af_lvl),
        .flags   (flags)
    );

    tf_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_go  (wr_go),
        .wr_ptr (wr_ptr),
        .din    (din),
        .rd_go  (rd_go),
        .rd_ptr (rd_ptr),
        .dout   (dout)
    );

    assign dout_en  = !oe_n;
    assign empty_n  = flags.empty_n;
    assign full_n   = flags.full_n;
    assign aempty_n = flags.aempty_n;
    assign afull_n  = flags.afull_n;
    assign hfull_n  = flags.hfull_n;

    // R12: an empty read leaves the data output untouched
    p_empty_read_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && !rd_en_n) |=> $stable(dout));

endmodule

// File: tb/thresh_fifo_tb.sv
`timescale 1ns/1ps
module thresh_fifo_tb;

    localparam int DEPTH = 256;
    localparam int DW    = 18;
    localparam int CW    = $clog2(DEPTH) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en_n = 1'b1;
    logic          rd_en_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [DW-1:0] din = '0;
    logic [CW-1:0] ae_lvl = CW'(3);
    logic [CW-1:0] af_lvl = CW'(4);
    logic [DW-1:0] dout;
    logic          dout_en, empty_n, full_n, aempty_n, afull_n, hfull_n;

    always #2 clk = ~clk;

    thresh_fifo #(.DEPTH(DEPTH), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .din(din),
        .rd_en_n(rd_en_n), .oe_n(oe_n), .ae_lvl(ae_lvl), .af_lvl(af_lvl),
        .dout(dout), .dout_en(dout_en), .empty_n(empty_n), .full_n(full_n),
        .aempty_n(aempty_n), .afull_n(afull_n), .hfull_n(hfull_n)
    );

    int            n_tests = 0;
    int            n_fail  = 0;
    int            mcnt    = 0;
    bit            chk_en  = 1'b0;
    bit            rd_pend = 1'b0;
    logic [DW-1:0] exp_dout = '0;
    logic [DW-1:0] exp_q[$];
    logic [DW-1:0] seq = 18'h100;
    int            n_s = 3;
    int            m_s = 4;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Thresholds as the design registered them at each edge
    always @(posedge clk) begin
        n_s <= int'(ae_lvl);
        m_s <= int'(af_lvl);
    end

    // Monitor: pops the scoreboard on each accepted read and checks every output
    always @(negedge clk) begin
        if (chk_en) begin
            if (rd_pend) begin
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R4 scoreboard empty actual=%0h expected=none", dout);
                end else begin
                    exp_dout = exp_q.pop_front();
                end
                rd_pend = 1'b0;
            end
            chk("R3/R4 dout", 32'(dout), 32'(exp_dout));
            chk("R6 empty_n", 32'(empty_n), 32'(mcnt != 0));
            chk("R7 full_n", 32'(full_n), 32'(mcnt != DEPTH));
            chk("R8 aempty_n", 32'(aempty_n), 32'(mcnt > n_s));
            chk("R9 afull_n", 32'(afull_n), 32'(mcnt + m_s < DEPTH));
            chk("R10 hfull_n", 32'(hfull_n), 32'(mcnt <= DEPTH / 2));
            chk("R11 dout_en", 32'(dout_en), 32'(!oe_n));
        end
    end

    // Driver: one clock of stimulus, entered and left at a falling edge
    task automatic op(input bit w, input bit r);
        bit wa, ra;
        wr_en_n = !w;
        rd_en_n = !r;
        din     = seq;
        wa = w && (mcnt < DEPTH);
        ra = r && (mcnt > 0);
        @(posedge clk);
        #1;
        if (wa) begin
            exp_q.push_back(seq);
            seq = seq + 18'h1;
        end
        if (ra) rd_pend = 1'b1;
        mcnt = mcnt + (wa ? 1 : 0) - (ra ? 1 : 0);
        @(negedge clk);
        wr_en_n = 1'b1;
        rd_en_n = 1'b1;
    endtask

    task automatic set_side(input int n, input int m, input bit oe_low);
        @(posedge clk);
        #1;
        ae_lvl = CW'(n);
        af_lvl = CW'(m);
        oe_n   = !oe_low;
        @(negedge clk);
    endtask

    task automatic do_reset();
        chk_en = 1'b0;
        rst_n  = 1'b0;
        @(posedge clk);
        #1;
        exp_q.delete();
        mcnt = 0;
        rd_pend = 1'b0;
        exp_dout = '0;
        @(negedge clk);
        chk("R1 empty_n", 32'(empty_n), 32'd0);
        chk("R1 full_n", 32'(full_n), 32'd1);
        chk("R1 aempty_n", 32'(aempty_n), 32'd0);
        chk("R1 afull_n", 32'(afull_n), 32'd1);
        chk("R1 hfull_n", 32'(hfull_n), 32'd1);
        chk("R1 dout", 32'(dout), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_en = 1'b1;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        do_reset();

        // R12: reads on an empty buffer, alone and with a write
        repeat (3) op(0, 1);
        chk("R12 dout after empty reads", 32'(dout), 32'd0);
        op(1, 1);
        chk("R12 write accepted, read ignored", 32'(empty_n), 32'd1);
        chk("R12 dout still zero", 32'(dout), 32'd0);
        op(0, 1);

        // R3 R4: short bursts with output enable toggled
        set_side(3, 4, 1'b1);
        for (int i = 0; i < 6; i++) op(1, 0);
        set_side(3, 4, 1'b0);
        for (int i = 0; i < 6; i++) op(0, 1);

        // R5: concurrent traffic at a steady occupancy
        op(1, 0);
        op(1, 0);
        for (int i = 0; i < 10; i++) op(1, 1);
        chk("R5 occupancy kept", 32'(mcnt), 32'd2);
        op(0, 1);
        op(0, 1);

        // R2 R7 R9 R10: fill to the top one word at a time, then strobe at full
        for (int i = 0; i < DEPTH + 3; i++) op(1, 0);
        chk("R2 full after overfill", 32'(full_n), 32'd0);
        op(1, 1);
        op(1, 0);
        chk("R2 refill after read", 32'(full_n), 32'd0);
        // R4 R8: drain through the low flags and past empty
        for (int i = 0; i < DEPTH + 2; i++) op(0, 1);
        chk("R2 nothing extra stored", 32'(empty_n), 32'd0);

        // Zero thresholds, walk across half-full and back
        set_side(0, 0, 1'b1);
        for (int i = 0; i < DEPTH / 2 + 2; i++) op(1, 0);
        for (int i = 0; i < 4; i++) op(1, 1);
        for (int i = 0; i < DEPTH / 2 + 2; i++) op(0, 1);

        // R1: reset with data present, then traffic from a clean start
        set_side(5, 7, 1'b0);
        for (int i = 0; i < 9; i++) op(1, 0);
        do_reset();
        for (int i = 0; i < 4; i++) op(1, 0);
        for (int i = 0; i < 5; i++) op(0, 1);

        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule